// File: doc/BRIEF.md
# Host-to-DSP Mailbox with Handshake Flags

This block sits on the DSP side of a host port. It moves 24-bit words in both directions between an external host processor and a DSP core. Each direction uses two register stages. A word the DSP core writes waits in a transmit holding register. It moves on its own into a three-byte host read window as soon as that window is free. A word the host builds byte by byte is staged on the host side. Once the DSP receive register is empty, the word moves into it.

A 16-bit status word reports the handshake state to the DSP core: receive full, transmit empty, command pending, two general-purpose host flags and a DMA-mode indication. The interrupt and DMA request levels are formed from these flags and the DSP-side enables. The host has a control register that carries the flags, its two mode bits and an initialize strobe. It also has a command register with one request bit. The initialize strobe returns both data-direction flags to their idle values.

Top module: `host_mailbox`

## Requirements
- R1: `status` bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is command-pending, bits 3 and 4 are host flags 0 and 1, and bit 7 is DMA status. All other bits read 0.
- R2: After a synchronous active-low reset, transmit-empty is 1. Receive-full, command-pending, the host flags, the host mode bits, the host read window and the host staging flag are all 0. A host read of address 0 then returns 8'h40.
- R3: A DSP write (`dsp_tx_we`) loads the transmit holding register and clears transmit-empty at that clock edge, unless an initialize happens in the same cycle.
- R4: The held word moves into the host read window at the first edge where three things are true: transmit-empty is 0, the window is empty, and no host data read is under way. That edge sets transmit-empty and sets window-full. The host reads the window as high, middle and low bytes at addresses 2, 3 and 4. A host read of address 0 returns window-full in bit 5 and staging-empty in bit 6. It returns host flag 0 and 1 in bits 0 and 1 and the two host mode bits in bits 2 and 3.
- R5: No move into the host window occurs in a cycle where `host_re` is high with an address in 2..4. A host read of address 4 empties the window at that edge.
- R6: The host writes bytes at addresses 2 (high), 3 (middle) and 4 (low). Writing address 4 stages the word. A staged word moves into `dsp_rx_data` at the first edge where receive-full is 0, and that edge sets receive-full. A DSP read (`dsp_rx_re`) clears receive-full.
- R7: `rx_irq` = receive-full AND `dsp_rx_ie`. `tx_irq` = transmit-empty AND `dsp_tx_ie`. `rx_dreq` = receive-full AND `rx_dma_en`. `tx_dreq` = transmit-empty AND `tx_dma_en`. All four are levels that follow the registered flags with no further delay.
- R8: A host write to address 0 with bit 4 set is an initialize. At that edge it clears receive-full and sets transmit-empty, and it takes priority over every other event on those two flags.
- R9: The host command request bit is bit 0 of address 1. Command-pending always equals it. `cmd_ack` clears it. A host write to address 1 in the same cycle takes priority over `cmd_ack`.
- R10: Status bits 3 and 4 always equal bits 0 and 1 last written by the host to address 0.
- R11: DMA status is 1 when `dsp_mode` is 3'b100 and at least one host mode bit (address 0 bits 2, 3) is set, or when `dsp_mode[0]` or `dsp_mode[1]` is 1. Otherwise it is 0.
- R12: `cmd_irq` equals command-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_tx_we | input | 1 | DSP write strobe for the transmit holding register |
| dsp_tx_data | input | 24 | DSP transmit word |
| dsp_rx_re | input | 1 | DSP read strobe for the receive register |
| dsp_rx_data | output | 24 | DSP receive register |
| dsp_rx_ie | input | 1 | Receive interrupt enable |
| dsp_tx_ie | input | 1 | Transmit interrupt enable |
| rx_dma_en | input | 1 | Receive DMA channel enabled |
| tx_dma_en | input | 1 | Transmit DMA channel enabled |
| dsp_mode | input | 3 | DSP-side mode field |
| cmd_ack | input | 1 | DSP core services the command interrupt |
| status | output | 16 | Handshake status word |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| cmd_irq | output | 1 | Command interrupt request |
| host_addr | input | 3 | Host register address |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0 when `host_re` is low |

## Verification
The two data paths are first exercised with single words and long idle gaps. These runs separate the per-edge transfer latency from the flag settling. The paths are then run with back-to-back words while the far side is still full, which shows whether the second register stage holds a word rather than overwriting one. The host window is read with repeated high-byte reads before the low byte, which shows whether a transfer is wrongly allowed during a read. Every DSP mode is swept against every host mode pair to cover the DMA-status formula. A long phase then drives all strobes together at random, including initialize and command writes that collide with acknowledges, so that each priority rule is exercised against a behavioural model on every clock.

// File: rtl/hmb_pkg.sv
// Shared constants for the host mailbox: host register addresses and
// bit positions in the host control word and the DSP status word.
package hmb_pkg;
    // Host address map (data lanes start at ADDR_DATA, high byte first)
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMD  = 1;
    localparam int ADDR_DATA = 2;

    // Host control register bits
    localparam int CB_HF0  = 0;
    localparam int CB_HF1  = 1;
    localparam int CB_HM0  = 2;
    localparam int CB_HM1  = 3;
    localparam int CB_INIT = 4;
    localparam int CTRL_W  = 5;

    // Extra read-only bits in the host control read-back
    localparam int RB_WIN_FULL  = 5;
    localparam int RB_STG_EMPTY = 6;

    // DSP status word bits
    localparam int SB_RXF = 0;
    localparam int SB_TXE = 1;
    localparam int SB_CMD = 2;
    localparam int SB_HF0 = 3;
    localparam int SB_HF1 = 4;
    localparam int SB_DMA = 7;

    // DSP mode value that hands DMA selection to the host
    localparam logic [2:0] MODE_HOSTSEL = 3'b100;
endpackage

// File: rtl/hmb_host_regs.sv
// Host-side register file: decodes host strobes, holds the host control
// flags/mode bits and the command request bit.
// Assumes one host access per cycle per strobe; reads have no side effect
// except the low-byte read reported through low_rd.
module hmb_host_regs
    import hmb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NB     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cmd_ack,
    output logic [NB-1:0]     lane_we,
    output logic              data_rd,
    output logic              low_rd,
    output logic              init,
    output logic [1:0]        hflag,
    output logic [1:0]        hmode,
    output logic              cmd_req
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(ADDR_CMD);
    localparam logic [ADDR_W-1:0] DLO_A  = ADDR_W'(ADDR_DATA);
    localparam logic [ADDR_W-1:0] DHI_A  = ADDR_W'(ADDR_DATA + NB - 1);

    logic in_data, ctrl_wr, cmd_wr;

    // Address decode for the host strobes
    always_comb begin
        in_data = (host_addr >= DLO_A) && (host_addr <= DHI_A);
        data_rd = host_re && in_data;
        low_rd  = host_re && (host_addr == DHI_A);
        ctrl_wr = host_we && (host_addr == CTRL_A);
        cmd_wr  = host_we && (host_addr == CMD_A);
        init    = ctrl_wr && ctrl_wdata[CB_INIT];
    end

    // Per-lane write enables, lane 0 = low byte at the highest data address
    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(ADDR_DATA + NB - 1 - i);
        assign lane_we[i] = host_we && (host_addr == LANE_A);
    end

    // Host control flags and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hflag <= '0;
            hmode <= '0;
        end else if (ctrl_wr) begin
            hflag <= {ctrl_wdata[CB_HF1], ctrl_wdata[CB_HF0]};
            hmode <= {ctrl_wdata[CB_HM1], ctrl_wdata[CB_HM0]};
        end
    end

    // Command request bit: host write wins over DSP acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_req <= 1'b0;
        else if (cmd_wr)  cmd_req <= ctrl_wdata[0];
        else if (cmd_ack) cmd_req <= 1'b0;
    end

    // R9
    cmd_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack && !cmd_wr |=> !cmd_req);
    // R9
    cmd_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && ctrl_wdata[0] |=> cmd_req);
endmodule

// File: rtl/hmb_dsp2host.sv
// DSP-to-host path: transmit holding register plus the host read window.
// A held word moves to an empty window one edge later unless the host is
// reading the window; reading the low byte empties the window.
module hmb_dsp2host #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_we,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              data_rd,
    input  logic              low_rd,
    input  logic              init,
    output logic              tx_empty,
    output logic [WORD_W-1:0] win_word,
    output logic              win_full
);
    logic [WORD_W-1:0] hold_word;
    logic              move;

    // Transfer condition: word held, window free, no host read in progress
    assign move = !tx_empty && !win_full && !data_rd;

    // Holding register load
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_word <= '0;
        else if (tx_we) hold_word <= tx_data;
    end

    // Transmit-empty flag: initialize, then DSP write, then transfer
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_empty <= 1'b1;
        else if (init)  tx_empty <= 1'b1;
        else if (tx_we) tx_empty <= 1'b0;
        else if (move)  tx_empty <= 1'b1;
    end

    // Host read window and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_word <= '0;
            win_full <= 1'b0;
        end else if (move) begin
            win_word <= hold_word;
            win_full <= 1'b1;
        end else if (low_rd) begin
            win_full <= 1'b0;
        end
    end

    // R3
    tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we && !init |=> !tx_empty);
    // R5
    no_move_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_full) |-> !$past(data_rd));
    // R5
    low_read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_rd |=> !win_full);
    // R8
    init_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> tx_empty);
endmodule

// File: rtl/hmb_host2dsp.sv
// Host-to-DSP path: byte-lane staging registers and the DSP receive register.
// Writing lane 0 (low byte) stages the word; it moves when receive is empty.
module hmb_host2dsp #(
    parameter int WORD_W = 24,
    parameter int BYTE_W = 8,
    parameter int NB     = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     lane_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_re,
    input  logic              init,
    output logic              stg_full,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_full
);
    logic [WORD_W-1:0] stg_word;
    logic              move;

    // One staging byte register per lane
    for (genvar i = 0; i < NB; i++) begin : g_stage
        logic [BYTE_W-1:0] lane_q;
        // Lane capture on host write
        always_ff @(posedge clk) begin
            if (!rst_n)          lane_q <= '0;
            else if (lane_we[i]) lane_q <= wdata;
        end
        assign stg_word[i*BYTE_W +: BYTE_W] = lane_q;
    end

    // Transfer condition: staged word present and receive register free
    assign move = stg_full && !rx_full;

    // Staging flag: low-byte write sets, transfer clears
    always_ff @(posedge clk) begin
        if (!rst_n)          stg_full <= 1'b0;
        else if (lane_we[0]) stg_full <= 1'b1;
        else if (move)       stg_full <= 1'b0;
    end

    // Receive register load
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_word <= '0;
        else if (move) rx_word <= stg_word;
    end

    // Receive-full flag: initialize, then transfer, then DSP read
    always_ff @(posedge clk) begin
        if (!rst_n)     rx_full <= 1'b0;
        else if (init)  rx_full <= 1'b0;
        else if (move)  rx_full <= 1'b1;
        else if (rx_re) rx_full <= 1'b0;
    end

    // R6
    dsp_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re && rx_full |=> !rx_full);
    // R6
    full_needs_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(stg_full));
    // R8
    init_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !rx_full);
endmodule

// File: rtl/host_mailbox.sv
// Top of the host mailbox: joins the host register file and both data
// paths, forms the DSP status word, request levels and host read data.
// Assumes WORD_W is a whole number of BYTE_W lanes and BYTE_W >= 7.
module host_mailbox
    import hmb_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_tx_we,
    input  logic [WORD_W-1:0] dsp_tx_data,
    input  logic              dsp_rx_re,
    output logic [WORD_W-1:0] dsp_rx_data,
    input  logic              dsp_rx_ie,
    input  logic              dsp_tx_ie,
    input  logic              rx_dma_en,
    input  logic              tx_dma_en,
    input  logic [2:0]        dsp_mode,
    input  logic              cmd_ack,
    output logic [STAT_W-1:0] status,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_dreq,
    output logic              tx_dreq,
    output logic              cmd_irq,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata
);
    localparam int NB = WORD_W / BYTE_W;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(ADDR_CMD);

    logic [NB-1:0]     lane_we;
    logic              data_rd, low_rd, init, cmd_req;
    logic [1:0]        hflag, hmode;
    logic              tx_empty, win_full, stg_full, rx_full, dma_on;
    logic [WORD_W-1:0] win_word;

    hmb_host_regs #(.ADDR_W(ADDR_W), .NB(NB)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_re(host_re), .ctrl_wdata(host_wdata[CTRL_W-1:0]),
        .cmd_ack(cmd_ack), .lane_we(lane_we), .data_rd(data_rd),
        .low_rd(low_rd), .init(init), .hflag(hflag), .hmode(hmode),
        .cmd_req(cmd_req)
    );

    hmb_dsp2host #(.WORD_W(WORD_W)) out_i (
        .clk(clk), .rst_n(rst_n), .tx_we(dsp_tx_we), .tx_data(dsp_tx_data),
        .data_rd(data_rd), .low_rd(low_rd), .init(init),
        .tx_empty(tx_empty), .win_word(win_word), .win_full(win_full)
    );

    hmb_host2dsp #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NB(NB)) in_i (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wdata(host_wdata),
        .rx_re(dsp_rx_re), .init(init), .stg_full(stg_full),
        .rx_word(dsp_rx_data), .rx_full(rx_full)
    );

    // DMA mode indication from DSP mode field and host mode bits
    assign dma_on = ((dsp_mode == MODE_HOSTSEL) && (|hmode))
                  || dsp_mode[0] || dsp_mode[1];

    // Status word assembly, unused bits held at zero
    always_comb begin
        status         = '0;
        status[SB_RXF] = rx_full;
        status[SB_TXE] = tx_empty;
        status[SB_CMD] = cmd_req;
        status[SB_HF0] = hflag[0];
        status[SB_HF1] = hflag[1];
        status[SB_DMA] = dma_on;
    end

    // Request levels from registered flags and enables
    always_comb begin
        rx_irq  = rx_full  && dsp_rx_ie;
        tx_irq  = tx_empty && dsp_tx_ie;
        rx_dreq = rx_full  && rx_dma_en;
        tx_dreq = tx_empty && tx_dma_en;
        cmd_irq = cmd_req;
    end

    // Host read multiplexer
    always_comb begin
        host_rdata = '0;
        if (host_re) begin
            if (host_addr == CTRL_A) begin
                host_rdata[CB_HF0]       = hflag[0];
                host_rdata[CB_HF1]       = hflag[1];
                host_rdata[CB_HM0]       = hmode[0];
                host_rdata[CB_HM1]       = hmode[1];
                host_rdata[RB_WIN_FULL]  = win_full;
                host_rdata[RB_STG_EMPTY] = !stg_full;
            end else if (host_addr == CMD_A) begin
                host_rdata[0] = cmd_req;
            end
            for (int i = 0; i < NB; i++) begin
                if (host_addr == ADDR_W'(ADDR_DATA + NB - 1 - i))
                    host_rdata = win_word[i*BYTE_W +: BYTE_W];
            end
        end
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00 && status[STAT_W-1:8] == '0);
endmodule

// File: tb/host_mailbox_tb.sv
`timescale 1ns/1ps
module host_mailbox_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic dsp_tx_we, dsp_rx_re, dsp_rx_ie, dsp_tx_ie, rx_dma_en, tx_dma_en, cmd_ack;
    logic [23:0] dsp_tx_data, dsp_rx_data;
    logic [2:0] dsp_mode, host_addr;
    logic [15:0] status;
    logic rx_irq, tx_irq, rx_dreq, tx_dreq, cmd_irq, host_we, host_re;
    logic [7:0] host_wdata, host_rdata;

    int vectors = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    host_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .dsp_tx_we(dsp_tx_we), .dsp_tx_data(dsp_tx_data),
        .dsp_rx_re(dsp_rx_re), .dsp_rx_data(dsp_rx_data), .dsp_rx_ie(dsp_rx_ie),
        .dsp_tx_ie(dsp_tx_ie), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .dsp_mode(dsp_mode), .cmd_ack(cmd_ack), .status(status), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .cmd_irq(cmd_irq),
        .host_addr(host_addr), .host_we(host_we), .host_re(host_re),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // Behavioural reference state
    logic [23:0] m_hold, m_win, m_rx;
    logic [7:0]  m_stg [3];       // index 0 = high, 2 = low
    bit m_txe, m_winf, m_stgf, m_rxf, m_cmd;
    bit [1:0] m_hf, m_hm;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_dma();
        return (dsp_mode == 3'b100 && m_hm != 0) || dsp_mode[0] || dsp_mode[1];
    endfunction

    task automatic compare_all();
        logic [7:0] er;
        if (!rst_n) return;
        chk("R6 rxf", 32'(status[0]), 32'(m_rxf));
        chk("R3 txe", 32'(status[1]), 32'(m_txe));
        chk("R9 cmd", 32'(status[2]), 32'(m_cmd));
        chk("R10 hf", 32'(status[4:3]), 32'(m_hf));
        chk("R11 dma", 32'(status[7]), 32'(m_dma()));
        chk("R1 rsvd", {16'h0, status[15:8], 1'b0, status[6:5], 5'h0}, 32'h0);
        chk("R7 req", {28'h0, rx_irq, tx_irq, rx_dreq, tx_dreq},
            {28'h0, m_rxf & dsp_rx_ie, m_txe & dsp_tx_ie, m_rxf & rx_dma_en, m_txe & tx_dma_en});
        chk("R12 cmdirq", 32'(cmd_irq), 32'(m_cmd));
        chk("R6 rxdata", 32'(dsp_rx_data), 32'(m_rx));
        er = 8'h00;
        if (host_re)
            case (host_addr)
                3'd0: er = {1'b0, !m_stgf, m_winf, 1'b0, m_hm, m_hf};
                3'd1: er = {7'h0, m_cmd};
                3'd2: er = m_win[23:16];
                3'd3: er = m_win[15:8];
                3'd4: er = m_win[7:0];
                default: er = 8'h00;
            endcase
        chk("R4 hrdata", 32'(host_rdata), 32'(er));
    endtask

    task automatic model_update();
        bit drd, lrd, ini, cwr, xo, xi;
        logic [23:0] stw;
        if (!rst_n) begin
            m_hold = 0; m_win = 0; m_rx = 0; m_txe = 1; m_winf = 0; m_stgf = 0;
            m_rxf = 0; m_cmd = 0; m_hf = 0; m_hm = 0;
            for (int i = 0; i < 3; i++) m_stg[i] = 0;
            return;
        end
        drd = host_re && host_addr >= 2 && host_addr <= 4;
        lrd = host_re && host_addr == 4;
        ini = host_we && host_addr == 0 && host_wdata[4];
        cwr = host_we && host_addr == 1;
        xo  = !m_txe && !m_winf && !drd;
        xi  = m_stgf && !m_rxf;
        stw = {m_stg[0], m_stg[1], m_stg[2]};
        if (xo) begin m_win = m_hold; m_winf = 1; end
        else if (lrd) m_winf = 0;
        if (ini) m_txe = 1; else if (dsp_tx_we) m_txe = 0; else if (xo) m_txe = 1;
        if (dsp_tx_we) m_hold = dsp_tx_data;
        if (xi) m_rx = stw;
        if (ini) m_rxf = 0; else if (xi) m_rxf = 1; else if (dsp_rx_re) m_rxf = 0;
        if (host_we && host_addr == 4) m_stgf = 1; else if (xi) m_stgf = 0;
        if (host_we && host_addr >= 2 && host_addr <= 4) m_stg[host_addr - 2] = host_wdata;
        if (cwr) m_cmd = host_wdata[0]; else if (cmd_ack) m_cmd = 0;
        if (host_we && host_addr == 0) begin m_hf = host_wdata[1:0]; m_hm = host_wdata[3:2]; end
    endtask

    task automatic tick();
        #1 compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(int n = 1);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic hw(logic [2:0] a, logic [7:0] d);
        host_addr = a; host_wdata = d; host_we = 1; tick(); host_we = 0;
    endtask

    task automatic hr(logic [2:0] a);
        host_addr = a; host_re = 1; tick(); host_re = 0;
    endtask

    task automatic dsp_wr(logic [23:0] d);
        dsp_tx_data = d; dsp_tx_we = 1; tick(); dsp_tx_we = 0;
    endtask

    task automatic dsp_rd();
        dsp_rx_re = 1; tick(); dsp_rx_re = 0;
    endtask

    task automatic host_word(logic [23:0] w);
        hw(3'd2, w[23:16]); hw(3'd3, w[15:8]); hw(3'd4, w[7:0]);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; dsp_tx_we = 0; dsp_rx_re = 0; dsp_rx_ie = 0; dsp_tx_ie = 0;
        rx_dma_en = 0; tx_dma_en = 0; cmd_ack = 0; dsp_tx_data = 0; dsp_mode = 0;
        host_addr = 0; host_we = 0; host_re = 0; host_wdata = 0;
        @(negedge clk);
        idle(3);
        rst_n = 1;
        // R2 reset state
        #1 chk("R2 status", 32'(status), 32'h0002);
        host_addr = 0; host_re = 1;
        #1 chk("R2 hostctrl", 32'(host_rdata), 32'h40);
        host_re = 0;
        idle(1);

        // R4 single word DSP to host, then host reads bytes
        dsp_wr(24'hA1B2C3); idle(3);
        hr(3'd0); hr(3'd2); hr(3'd3); hr(3'd4); idle(2);

        // R5 second word waits while window full; repeated high reads block move
        dsp_wr(24'h112233); idle(2);
        dsp_wr(24'h445566); idle(1);
        hr(3'd4);                     // empties window
        hr(3'd2); hr(3'd2); hr(3'd3); // move blocked during these reads
        #1 chk("R5 blocked", 32'(status[1]), 32'h0);
        idle(1);
        hr(3'd0); hr(3'd2); hr(3'd4); idle(2);

        // R6 host to DSP, back to back while receive full
        dsp_rx_ie = 1; rx_dma_en = 1; dsp_tx_ie = 1; tx_dma_en = 1;
        host_word(24'hDEAD01); idle(2);
        host_word(24'hBEEF02); hr(3'd0); idle(2);
        dsp_rd(); idle(2); dsp_rd(); idle(1);
        dsp_rx_ie = 0; tx_dma_en = 0; idle(1);

        // R9 / R12 command handling
        hw(3'd1, 8'h01); idle(1); cmd_ack = 1; tick(); cmd_ack = 0;
        hw(3'd1, 8'h01); hw(3'd1, 8'h00); hw(3'd1, 8'h01);
        host_addr = 1; host_wdata = 8'h01; host_we = 1; cmd_ack = 1; tick();
        host_we = 0; cmd_ack = 0; hr(3'd1);

        // R10 / R11 flags and mode sweep
        for (int hm = 0; hm < 4; hm++)
            for (int md = 0; md < 8; md++) begin
                hw(3'd0, 8'((hm << 2) | (md & 3)));
                dsp_mode = 3'(md); idle(1);
            end
        dsp_mode = 0;

        // R8 initialize with data pending on both sides
        dsp_wr(24'h0F0F0F); host_word(24'h777777); dsp_wr(24'h123456);
        hw(3'd0, 8'h10);
        #1 chk("R8 init", 32'(status[1:0]), 32'h2);
        idle(2); hr(3'd4); idle(2);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            dsp_tx_we = ($urandom_range(0, 3) == 0); dsp_tx_data = 24'($urandom);
            dsp_rx_re = ($urandom_range(0, 2) == 0);
            dsp_rx_ie = 1'($urandom); dsp_tx_ie = 1'($urandom);
            rx_dma_en = 1'($urandom); tx_dma_en = 1'($urandom);
            dsp_mode = 3'($urandom); cmd_ack = ($urandom_range(0, 3) == 0);
            host_addr = 3'($urandom_range(0, 5));
            host_we = ($urandom_range(0, 2) == 0); host_re = ($urandom_range(0, 1) == 0);
            host_wdata = 8'($urandom);
            if (host_addr == 0 && $urandom_range(0, 3) != 0) host_wdata[4] = 0;
            tick();
        end
        dsp_tx_we = 0; dsp_rx_re = 0; cmd_ack = 0; host_we = 0; host_re = 0;
        idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule